// File: doc/BRIEF.md
# Unsigned Difference Unit with Sign and Magnitude Result

This block subtracts one unsigned W-bit operand from another, M minus N, and returns a sign flag plus a true magnitude. It does not return a result that has wrapped modulo 2^W. A single ripple adder/subtractor core does the arithmetic. The core inverts its second operand through XOR gates and sets the carry into bit 0 when subtraction is selected.

The first pass uses the core to compute M minus N. When the carry out is 1, no borrow occurred, so M >= N and the low bits are already the answer. When the carry out is 0, the raw result equals M - N + 2^W. The block then runs a second pass on the same core, subtracting the raw value from zero. This two's complement step yields N - M, and the sign is set.

A one-cycle start strobe launches an operation. A one-cycle done pulse reports completion. The result then stays on the outputs until the next accepted start.

Top module: `usub_mag_top`

## Requirements
- R1: When M > N, done_o is high on the cycle after the accepted start, with sign_o = 0 and mag_o = M - N.
- R2: When M < N, done_o stays low on the cycle after the accepted start and is high on the following cycle, with sign_o = 1 and mag_o = N - M.
- R3: When M = N, the block completes in one cycle, with sign_o = 0 and mag_o = 0, and runs no correction pass.
- R4: done_o is high for exactly one cycle per operation.
- R5: sign_o and mag_o change only on a cycle where done_o is high, and hold their values between operations.
- R6: A start_i that arrives during the correction cycle is ignored. The operation in flight completes with its own operands, and no further done pulse follows.
- R7: valid_o falls on the cycle after a start is accepted and rises together with done_o.
- R8: After reset, done_o, valid_o, sign_o and mag_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, taken when idle |
| m_i | input | W | Minuend, sampled on the accepted start |
| n_i | input | W | Subtrahend, sampled on the accepted start |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Result on sign_o/mag_o is current |
| sign_o | output | 1 | 1 when N > M |
| mag_o | output | W | Absolute value of M - N |

## Verification
The operand pairs cover M > N, M < N and M = N. These cases separate the single-pass path from the correction path and test the equality boundary, where a wrong borrow test would add a needless cycle. Extreme pairs (0 and all-ones in either order, 0 minus 1, all-ones minus all-ones) expose errors in the carry-in or the XOR inversion at the ends of the carry chain. Random pairs cover the remaining range. Each operation is followed by idle cycles, where the bench checks that the outputs hold. A start pulse with different operands is placed in the correction cycle, where it must leave the result unchanged.

// File: rtl/usub_pkg.sv
package usub_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CORR = 1'b1
  } usub_state_e;
endpackage

// File: rtl/usub_addsub_core.sv
module usub_addsub_core #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] b_x;

  always_comb begin
    logic carry;
    carry = sub_i;
    for (int i = 0; i < W; i++) begin
      b_x[i]   = b_i[i] ^ sub_i;
      sum_o[i] = a_i[i] ^ b_x[i] ^ carry;
      carry    = (a_i[i] & b_x[i]) | (carry & (a_i[i] ^ b_x[i]));
    end
    cout_o = carry;
  end
endmodule

// File: rtl/usub_ctrl.sv
module usub_ctrl
  import usub_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] sum_i,
  input  logic         cout_i,
  output logic         corr_o,
  output logic [W-1:0] raw_o,
  output logic         done_o,
  output logic         valid_o,
  output logic         sign_o,
  output logic [W-1:0] mag_o
);
  usub_state_e state_q;

  assign corr_o = (state_q == ST_CORR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      raw_o   <= '0;
      done_o  <= 1'b0;
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      mag_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (cout_i) begin
              // no borrow: first pass is final
              mag_o   <= sum_i;
              sign_o  <= 1'b0;
              done_o  <= 1'b1;
              valid_o <= 1'b1;
            end else begin
              raw_o   <= sum_i;
              valid_o <= 1'b0;
              state_q <= ST_CORR;
            end
          end
        end
        ST_CORR: begin
          mag_o   <= sum_i;
          sign_o  <= 1'b1;
          done_o  <= 1'b1;
          valid_o <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usub_mag_top.sv
module usub_mag_top #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] n_i,
  output logic         done_o,
  output logic         valid_o,
  output logic         sign_o,
  output logic [W-1:0] mag_o
);
  localparam logic SUB_SEL = 1'b1;

  logic         corr;
  logic [W-1:0] raw;
  logic [W-1:0] core_a, core_b, core_sum;
  logic         core_cout;

  // pass 1: M - N ; pass 2: 0 - raw
  assign core_a = corr ? '0  : m_i;
  assign core_b = corr ? raw : n_i;

  usub_addsub_core #(.W(W)) u_core (
    .a_i    (core_a),
    .b_i    (core_b),
    .sub_i  (SUB_SEL),
    .sum_o  (core_sum),
    .cout_o (core_cout)
  );

  usub_ctrl #(.W(W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .sum_i   (core_sum),
    .cout_i  (core_cout),
    .corr_o  (corr),
    .raw_o   (raw),
    .done_o  (done_o),
    .valid_o (valid_o),
    .sign_o  (sign_o),
    .mag_o   (mag_o)
  );
endmodule

// File: rtl/usub_mag_chk.sv
module usub_mag_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] m_i,
  input logic [W-1:0] n_i,
  input logic         busy_i,
  input logic         done_o,
  input logic         valid_o,
  input logic         sign_o,
  input logic [W-1:0] mag_o
);
  logic take;
  assign take = start_i && !busy_i;

  AST_POS_ONE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (m_i > n_i) |=> done_o && !sign_o && (mag_o == $past(m_i) - $past(n_i))); // R1

  AST_NEG_TWO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (m_i < n_i) |=> !done_o ##1 (done_o && sign_o)); // R2

  AST_EQ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (m_i == n_i) |=> done_o && !sign_o && (mag_o == '0)); // R3

  AST_CORR_DONE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> done_o ##1 !done_o); // R4

  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(mag_o) && $stable(sign_o)); // R5

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && start_i |=> done_o && sign_o); // R6

  AST_VALID_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o); // R7

  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (m_i < n_i) |=> !valid_o); // R7
endmodule

bind usub_mag_top usub_mag_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .m_i     (m_i),
  .n_i     (n_i),
  .busy_i  (corr),
  .done_o  (done_o),
  .valid_o (valid_o),
  .sign_o  (sign_o),
  .mag_o   (mag_o)
);

// File: tb/usub_mag_top_tb.sv
module usub_mag_top_tb;
  localparam int W   = 8;
  localparam int MAX = (1 << W) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] m_i = '0;
  logic [W-1:0] n_i = '0;
  logic         done_o, valid_o, sign_o;
  logic [W-1:0] mag_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  usub_mag_top #(.W(W)) u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .m_i     (m_i),
    .n_i     (n_i),
    .done_o  (done_o),
    .valid_o (valid_o),
    .sign_o  (sign_o),
    .mag_o   (mag_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one operation; poke injects a start during the correction cycle
  task automatic run(input int m, input int n, input bit poke);
    int exp_mag;
    int exp_sign;
    exp_sign = (m < n) ? 1 : 0;
    exp_mag  = (m < n) ? n - m : m - n;
    @(negedge clk_i);
    m_i = W'(m); n_i = W'(n); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; m_i = ~W'(m); n_i = W'(n + 7);
    if (exp_sign == 0) begin
      chk((m == n) ? "R3 done" : "R1 done", int'(done_o), 1);
      chk((m == n) ? "R3 sign" : "R1 sign", int'(sign_o), 0);
      chk((m == n) ? "R3 mag"  : "R1 mag",  int'(mag_o), exp_mag);
      chk("R7 valid at done", int'(valid_o), 1);
    end else begin
      chk("R2 no done after pass 1", int'(done_o), 0);
      chk("R7 valid dropped", int'(valid_o), 0);
      if (poke) begin
        start_i = 1'b1; m_i = W'(MAX); n_i = '0;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      chk(poke ? "R6 done" : "R2 done", int'(done_o), 1);
      chk(poke ? "R6 sign" : "R2 sign", int'(sign_o), 1);
      chk(poke ? "R6 mag"  : "R2 mag",  int'(mag_o), exp_mag);
      chk("R7 valid at done", int'(valid_o), 1);
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk_i);
      chk(poke ? "R6 no extra done" : "R4 done pulse", int'(done_o), 0);
      chk("R5 mag held", int'(mag_o), exp_mag);
      chk("R5 sign held", int'(sign_o), exp_sign);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8 done reset", int'(done_o), 0);
    chk("R8 valid reset", int'(valid_o), 0);
    chk("R8 sign reset", int'(sign_o), 0);
    chk("R8 mag reset", int'(mag_o), 0);
    rst_ni = 1'b1;

    run(100, 150, 1'b0);   // R2: raw 206 corrects to 50
    run(150, 100, 1'b0);   // R1
    run(77, 77, 1'b0);     // R3
    run(0, 0, 1'b0);       // R3
    run(MAX, MAX, 1'b0);   // R3
    run(MAX, 0, 1'b0);     // R1
    run(0, MAX, 1'b0);     // R2
    run(0, 1, 1'b0);       // R2
    run(1, 0, 1'b0);       // R1
    run(3, 200, 1'b1);     // R6
    for (int i = 0; i < 60; i++) begin
      int a;
      int b;
      a = int'($urandom_range(MAX, 0));
      b = int'($urandom_range(MAX, 0));
      run(a, b, (i % 4) == 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule